// File: doc/BRIEF.md
# Serial Field-Memory Write Port

This block is the write side of a first-in first-out field store. A byte stream arrives on a single write clock. Two enables gate it in different ways. The write enable stops the stream: the address pointer freezes and nothing is taken. The input enable only masks the store: the location keeps its old contents, but the pointer still steps on. A write-reset input returns the pointer to location zero so that a new field can begin.

Every control input first passes through one extra register stage. This makes the write side one clock later than the matching read timing, so chained devices can connect output to input with no delay element between them. A captured byte is held in a one-word posting buffer. It is sent to the storage array, as a strobe with address and data, only when the next active cycle or a write reset is processed. The final word of a field therefore reaches the array only through a closing write reset. Two protocol monitors raise one-cycle flags when the reset is re-armed too soon or when a field is too short.

Top module: `field_wr_port`

## Requirements
- R1: While `rst_ni` is low and in the first cycle after it rises, `wr_ptr_o` is 0 and `wr_stb_o`, `gap_err_o` and `short_seq_o` are 0.
- R2: A write-clock edge that samples `wr_rst_i` high sets the pointer to 0 and empties the posting buffer. `wr_en_i`, `in_en_i` and `din_i` on that edge have no effect: no byte is taken and no later strobe carries it.
- R3: An edge that samples `wr_en_i` high, with reset low, takes `din_i` and advances the pointer by one. An edge that samples `wr_en_i` low, with reset low, leaves the pointer unchanged and takes nothing.
- R4: When `wr_en_i` is high and `in_en_i` is low, the pointer still advances, but no strobe is ever issued for that address.
- R5: Inputs sampled on edge n take effect on the pointer at edge n+1, so `wr_ptr_o` changes one cycle later than it would without the skew stage.
- R6: A taken byte is held back. It is issued as `wr_stb_o`=1 with `wr_addr_o` equal to the pointer at capture and `wr_data_o` equal to the byte, during the cycle after the next active or reset cycle is processed. Idle cycles do not issue it.
- R7: When a reset rising is processed after fewer than 2 reset-low cycles since the previous reset, `gap_err_o` pulses for one cycle. The first reset after power-on is not checked.
- R8: When a reset rising is processed and the field since the previous reset had fewer than `MIN_ACTIVE` (default 80) cycles with `wr_en_i` high, `short_seq_o` pulses for one cycle. The first reset after power-on is not checked.
- R9: The pointer is `ADDR_W` bits wide (default 18) and wraps from its maximum value to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial write clock, rising edge |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| wr_rst_i | input | 1 | Field write reset, sampled on the clock |
| wr_en_i | input | 1 | Write enable: takes data and advances the pointer |
| in_en_i | input | 1 | Input enable: write mask, does not stop the pointer |
| din_i | input | DATA_W | Input byte |
| wr_stb_o | output | 1 | Array write strobe |
| wr_addr_o | output | ADDR_W | Array write address |
| wr_data_o | output | DATA_W | Array write data |
| wr_ptr_o | output | ADDR_W | Current write pointer |
| gap_err_o | output | 1 | Reset re-armed too soon (one-cycle pulse) |
| short_seq_o | output | 1 | Field shorter than MIN_ACTIVE (one-cycle pulse) |

## Verification
Two functions share a cycle whenever a write reset is sampled. In that cycle the posting buffer must flush the previous field's last word, and the pointer must clear, while the byte and enables on the reset edge are thrown away. The stimulus table provokes this with a reset that has `wr_en_i` and `in_en_i` held high. The check requires the strobe to carry the earlier word and address, the pointer to read 0, and the next cycle to carry no strobe. The same overlap occurs on every active cycle, where flushing one word and capturing the next coincide. A masked word placed between two unmasked ones shows that the flush passes over it while the pointer still counts it.

// File: rtl/fwp_pkg.sv
package fwp_pkg;
  typedef struct packed {
    logic rst;
    logic we;
    logic ie;
  } fwp_ctl_t;

  localparam int unsigned GAP_MIN = 2;
endpackage

// File: rtl/fwp_skew.sv
module fwp_skew
  import fwp_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SKEW   = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  fwp_ctl_t          ctl_i,
  input  logic [DATA_W-1:0] data_i,
  output fwp_ctl_t          ctl_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int unsigned W = $bits(fwp_ctl_t) + DATA_W;

  logic [SKEW-1:0][W-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_q <= '0;
    end else begin
      pipe_q[0] <= {ctl_i, data_i};
      for (int s = 1; s < int'(SKEW); s++) pipe_q[s] <= pipe_q[s-1];
    end
  end

  assign {ctl_o, data_o} = pipe_q[SKEW-1];

  // R5
  skew_first_stage_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> pipe_q[0] == $past({ctl_i, data_i}));
endmodule

// File: rtl/fwp_pointer.sv
module fwp_pointer
  import fwp_pkg::*;
#(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  fwp_ctl_t          ctl_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              stb_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic [ADDR_W-1:0] ptr_o
);
  logic [ADDR_W-1:0] ptr_q;
  logic              pend_vld_q;
  logic [ADDR_W-1:0] pend_addr_q;
  logic [DATA_W-1:0] pend_data_q;
  logic              stb_q;
  logic [ADDR_W-1:0] stb_addr_q;
  logic [DATA_W-1:0] stb_data_q;
  logic              act;
  logic              flush;

  assign act   = ctl_i.we && !ctl_i.rst;
  assign flush = (ctl_i.rst || ctl_i.we) && pend_vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q       <= '0;
      pend_vld_q  <= 1'b0;
      pend_addr_q <= '0;
      pend_data_q <= '0;
      stb_q       <= 1'b0;
      stb_addr_q  <= '0;
      stb_data_q  <= '0;
    end else begin
      stb_q <= flush;
      if (flush) begin
        stb_addr_q <= pend_addr_q;
        stb_data_q <= pend_data_q;
      end
      if (ctl_i.rst) begin
        ptr_q      <= '0;
        pend_vld_q <= 1'b0;
      end else if (act) begin
        pend_vld_q  <= ctl_i.ie;
        pend_addr_q <= ptr_q;
        pend_data_q <= data_i;
        ptr_q       <= ptr_q + ADDR_W'(1);
      end
    end
  end

  assign stb_o  = stb_q;
  assign addr_o = stb_addr_q;
  assign data_o = stb_data_q;
  assign ptr_o  = ptr_q;

  // R2
  rst_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_i.rst |=> (ptr_q == '0) && !pend_vld_q);
  // R3
  we_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl_i.rst && !ctl_i.we) |=> $stable(ptr_q) && !$rose(pend_vld_q));
  // R9
  ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl_i.rst && ctl_i.we) |=> ptr_q == $past(ptr_q) + ADDR_W'(1));
  // R4
  mask_no_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl_i.rst && ctl_i.we && !ctl_i.ie) |=> !pend_vld_q);
  // R6
  stb_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_q |-> $past(ctl_i.rst || ctl_i.we));
endmodule

// File: rtl/fwp_rules.sv
module fwp_rules
  import fwp_pkg::*;
#(
  parameter int unsigned MIN_ACTIVE = 80
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rst_i,
  input  logic we_i,
  output logic gap_err_o,
  output logic short_seq_o
);
  localparam int unsigned ACT_W = $clog2(MIN_ACTIVE + 1);
  localparam int unsigned GAP_W = $clog2(GAP_MIN + 1);

  logic             rst_prev_q;
  logic             seen_q;
  logic [GAP_W-1:0] gap_q;
  logic [ACT_W-1:0] act_q;
  logic             gap_err_q;
  logic             short_q;
  logic             rise;

  assign rise = rst_i && !rst_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_prev_q <= 1'b0;
      seen_q     <= 1'b0;
      gap_q      <= '0;
      act_q      <= '0;
      gap_err_q  <= 1'b0;
      short_q    <= 1'b0;
    end else begin
      rst_prev_q <= rst_i;
      gap_err_q  <= rise && seen_q && (gap_q < GAP_W'(GAP_MIN));
      short_q    <= rise && seen_q && (act_q < ACT_W'(MIN_ACTIVE));
      if (rst_i) begin
        seen_q <= 1'b1;
        gap_q  <= '0;
        act_q  <= '0;
      end else begin
        if (gap_q < GAP_W'(GAP_MIN)) gap_q <= gap_q + GAP_W'(1);
        if (we_i && act_q < ACT_W'(MIN_ACTIVE)) act_q <= act_q + ACT_W'(1);
      end
    end
  end

  assign gap_err_o   = gap_err_q;
  assign short_seq_o = short_q;

  // R7
  gap_err_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_err_q |-> $past(rst_i) && !$past(rst_prev_q));
  // R8
  short_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    short_q |-> $past(rst_i) && $past(seen_q));
  // R7
  gap_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_err_q |=> !gap_err_q);
  // R8
  act_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q <= ACT_W'(MIN_ACTIVE));
endmodule

// File: rtl/field_wr_port.sv
module field_wr_port
  import fwp_pkg::*;
#(
  parameter int unsigned ADDR_W     = 18,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned MIN_ACTIVE = 80,
  parameter int unsigned SKEW       = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_rst_i,
  input  logic              wr_en_i,
  input  logic              in_en_i,
  input  logic [DATA_W-1:0] din_i,
  output logic              wr_stb_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic [ADDR_W-1:0] wr_ptr_o,
  output logic              gap_err_o,
  output logic              short_seq_o
);
  fwp_ctl_t          ctl_in;
  fwp_ctl_t          ctl_d;
  logic [DATA_W-1:0] data_d;

  assign ctl_in = '{rst: wr_rst_i, we: wr_en_i, ie: in_en_i};

  fwp_skew #(.DATA_W(DATA_W), .SKEW(SKEW)) u_skew (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ctl_i  (ctl_in),
    .data_i (din_i),
    .ctl_o  (ctl_d),
    .data_o (data_d)
  );

  fwp_pointer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ctl_i  (ctl_d),
    .data_i (data_d),
    .stb_o  (wr_stb_o),
    .addr_o (wr_addr_o),
    .data_o (wr_data_o),
    .ptr_o  (wr_ptr_o)
  );

  fwp_rules #(.MIN_ACTIVE(MIN_ACTIVE)) u_rules (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_i       (ctl_d.rst),
    .we_i        (ctl_d.we),
    .gap_err_o   (gap_err_o),
    .short_seq_o (short_seq_o)
  );

  // R1
  por_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !wr_stb_o && !gap_err_o && !short_seq_o);
endmodule

// File: tb/field_wr_port_test.sv
module field_wr_port_test;
  localparam int unsigned AW = 8;
  localparam int unsigned DW = 8;
  localparam int unsigned NV = 13;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_rst = 1'b0, wr_en = 1'b0, in_en = 1'b0;
  logic [DW-1:0] din = '0;
  logic          stb, gap_err, short_seq;
  logic [AW-1:0] addr, ptr;
  logic [DW-1:0] data;
  int            n_chk = 0, n_bad = 0;
  bit            done = 1'b0;

  always #5 clk = ~clk;

  field_wr_port #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_rst_i(wr_rst), .wr_en_i(wr_en),
    .in_en_i(in_en), .din_i(din), .wr_stb_o(stb), .wr_addr_o(addr),
    .wr_data_o(data), .wr_ptr_o(ptr), .gap_err_o(gap_err), .short_seq_o(short_seq)
  );

  // {rst,we,ie,din | exp stb,addr,data,ptr,err,warn}; expectations show the effect of row i-2
  function automatic logic [37:0] v(logic r, logic w, logic e, logic [7:0] d,
                                    logic xs, logic [7:0] xa, logic [7:0] xd,
                                    logic [7:0] xp, logic xe, logic xw);
    return {r, w, e, d, xs, xa, xd, xp, xe, xw};
  endfunction

  localparam logic [37:0] TBL [NV] = '{
    v(1,0,0,8'h00, 0,8'h00,8'h00,8'h00,0,0),  // first reset after POR
    v(0,1,1,8'hA0, 0,8'h00,8'h00,8'h00,0,0),
    v(0,1,0,8'hA1, 0,8'h00,8'h00,8'h00,0,0),  // masked word (R4)
    v(0,1,1,8'hA2, 0,8'h00,8'h00,8'h01,0,0),
    v(0,0,1,8'hA3, 1,8'h00,8'hA0,8'h02,0,0),  // WE low
    v(0,1,1,8'hA4, 0,8'h00,8'h00,8'h03,0,0),
    v(1,1,1,8'hFF, 0,8'h00,8'h00,8'h03,0,0),  // reset with WE/IE high (R2)
    v(0,1,1,8'hB0, 1,8'h02,8'hA2,8'h04,0,0),
    v(1,0,0,8'h00, 1,8'h03,8'hA4,8'h00,0,1),  // reset after one low cycle
    v(0,0,0,8'h00, 0,8'h00,8'h00,8'h01,0,0),
    v(0,0,0,8'h00, 1,8'h00,8'hB0,8'h00,1,1),
    v(0,0,0,8'h00, 0,8'h00,8'h00,8'h00,0,0),
    v(0,0,0,8'h00, 0,8'h00,8'h00,8'h00,0,0)
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input logic r, input logic w, input logic e, input logic [7:0] d);
    wr_rst = r; wr_en = w; in_en = e; din = d;
    tick();
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during power-on reset
    chk(ptr == 0 && !stb && !gap_err && !short_seq, "R1", {ptr, 3'(stb)}, 0);
    rst_n = 1'b1;
    tick();
    chk(ptr == 0 && !stb && !gap_err && !short_seq, "R1", {ptr, 3'(stb)}, 0);
    tick();

    for (int i = 0; i < int'(NV); i++) begin
      logic [37:0] e;
      e = TBL[i];
      chk(ptr == e[9:2], "R3", ptr, e[9:2]);
      chk(stb == e[26], "R6", stb, e[26]);
      if (e[26]) begin
        chk(addr == e[25:18], "R6", addr, e[25:18]);
        chk(data == e[17:10], "R6", data, e[17:10]);
      end
      chk(gap_err == e[1], "R7", gap_err, e[1]);
      chk(short_seq == e[0], "R8", short_seq, e[0]);
      drive(e[37], e[36], e[35], e[34:27]);
    end

    // R5: one cycle of skew
    drive(0, 1, 1, 8'h5A);
    chk(ptr == 0, "R5", ptr, 0);
    drive(0, 0, 0, 8'h00);
    chk(ptr == 1, "R5", ptr, 1);
    // R6: idle cycles do not commit
    for (int k = 0; k < 4; k++) begin
      drive(0, 0, 0, 8'h00);
      chk(!stb, "R6", stb, 0);
    end
    // R2: reset with WE/IE high commits old word, new byte discarded
    drive(1, 1, 1, 8'hEE);
    drive(0, 0, 0, 8'h00);
    chk(ptr == 0, "R2", ptr, 0);
    chk(stb && addr == 0 && data == 8'h5A, "R6", {addr, data}, 16'h005A);
    chk(short_seq, "R8", short_seq, 1);
    drive(0, 0, 0, 8'h00);
    chk(!stb, "R2", stb, 0);

    // R8: exactly 80 active cycles is enough
    for (int k = 0; k < 80; k++) drive(0, 1, 1, 8'(k));
    drive(1, 0, 0, 8'h00);
    drive(0, 0, 0, 8'h00);
    chk(!short_seq, "R8", short_seq, 0);
    chk(!gap_err, "R7", gap_err, 0);
    chk(stb && addr == 79 && data == 79, "R6", {addr, data}, 16'h4F4F);
    // R8: 79 is too few
    for (int k = 0; k < 79; k++) drive(0, 1, 1, 8'(k));
    drive(1, 0, 0, 8'h00);
    drive(0, 0, 0, 8'h00);
    chk(short_seq, "R8", short_seq, 1);

    // R4: masked word never strobed, pointer still advances
    drive(0, 1, 0, 8'h77);
    drive(0, 1, 1, 8'h78);
    drive(0, 0, 0, 8'h00);
    chk(!stb, "R4", stb, 0);
    chk(ptr == 2, "R4", ptr, 2);
    drive(1, 0, 0, 8'h00);
    drive(0, 0, 0, 8'h00);
    chk(stb && addr == 1 && data == 8'h78, "R4", {addr, data}, 16'h0178);

    // R9: wrap after 2^AW active cycles
    for (int k = 0; k < (1 << AW); k++) drive(0, 1, 1, 8'(k));
    drive(0, 0, 0, 8'h00);
    chk(ptr == 0, "R9", ptr, 0);
    drive(0, 1, 1, 8'hAB);
    drive(0, 0, 0, 8'h00);
    chk(ptr == 1, "R9", ptr, 1);
    chk(stb && addr == 8'hFF && data == 8'hFF, "R9", {addr, data}, 16'hFFFF);
    drive(1, 0, 0, 8'h00);
    drive(0, 0, 0, 8'h00);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule